// File: doc/BRIEF.md
# Four-Bank Synchronous DRAM Command and Burst Engine

This block models the device side of a synchronous DRAM. On every rising clock edge it takes one complete command (no-op, activate, read, write or precharge) together with a bank number and an address. For each of its four banks it remembers whether a row is open and which one, and it runs three per-bank countdown timers. The three minimum spacings they enforce are activate-to-access, activate-to-precharge and precharge-to-activate. Commands that break the bank state or a timer are refused and reported on a one-cycle error pulse.

A read or write names only the first column. The engine then produces the remaining column addresses of a 4- or 8-beat burst on its own, one per cycle, wrapping inside the block of columns aligned to the burst length. Write data is sampled once per beat. Read data comes out on a data bus with a valid flag, 2 or 3 cycles after each beat is addressed. A small behavioural array holds the contents, split evenly across the four banks.

Because the timers are per bank, an activate or precharge to one bank can be issued while a burst streams from another. A new access issued right after the final beat continues the data stream with no idle cycle.

Top module: `sdram_bank_engine`

## Requirements
- R1: Command, bank, address and mode inputs are sampled only at the rising clock edge. The error pulse for a command appears on `err` in the cycle after the edge that sampled it. Command codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge; codes 5 to 7 are illegal and raise `err`.
- R2: An activate to a bank that already has an open row raises `err` and leaves the bank unchanged. A read or write to a bank with no open row also raises `err` and leaves the bank unchanged.
- R3: A read or write is accepted only if at least `t_rcd` cycles have passed since the activate of that bank; otherwise it raises `err` and is ignored.
- R4: An activate is accepted only if at least `t_rp` cycles have passed since the precharge of that bank; otherwise it raises `err` and is ignored.
- R5: A precharge to an open bank is accepted only if at least `t_ras` cycles have passed since its activate; otherwise it raises `err` and the row stays open.
- R6: A burst has 8 beats when `bl8` is 1 at the command and 4 beats otherwise. Beat i addresses column {start[high bits], (start[low bits] + i) mod BL}, where the low field is 2 bits for BL 4 and 3 bits for BL 8.
- R7: The data of beat i of a read issued at edge k is on `rdata` with `rvalid` high in the cycle after edge k+i+CL-1. CL is 3 when `cas3` is 1 and 2 otherwise; `rvalid` is low when no read data is due.
- R8: A write stores `wdata` sampled at each beat edge into that beat's column of the open row.
- R9: A read or write issued while a burst still has beats left raises `err` and is ignored. One issued at the edge after the last beat is accepted, so read data continues without a gap.
- R10: An activate to another bank during a burst is accepted and does not disturb the burst's addresses or data.
- R11: A precharge to the bank under an unfinished burst raises `err`. A precharge to a bank with no open row has no effect and raises no error.
- R12: Reset (active-low `rst_n`) closes every bank, clears all timers and any burst, and holds `err` and `rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code |
| bank | input | 2 | Target bank |
| addr | input | 4 | Row on activate, start column on read/write |
| wdata | input | 8 | Write data for the current beat |
| bl8 | input | 1 | Burst length select: 1 gives 8 beats, 0 gives 4 |
| cas3 | input | 1 | Read latency select: 1 gives 3 cycles, 0 gives 2 |
| t_rcd | input | 4 | Activate-to-access spacing in cycles |
| t_rp | input | 4 | Precharge-to-activate spacing in cycles |
| t_ras | input | 4 | Activate-to-precharge spacing in cycles |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | Read data valid |
| err | output | 1 | Refused or illegal command, one cycle after it |

## Verification
A bank whose open flag or row is wrong shows up as an unexpected `err` one cycle after the next command to that bank. It can also show as read data from the wrong row, which appears CL cycles after the first beat. A timer off by one shifts the first accepted command by a cycle and moves the error pulse with it. A wrong burst counter or wrap shows as a misordered or gapped `rdata` stream within at most eight cycles.

// File: rtl/sdram_bank_engine.sv
module sdram_bank_engine #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int TW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bl8,
  input  logic              cas3,
  input  logic [TW-1:0]     t_rcd,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_ras,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);
  localparam int NBANK = 1 << BANK_W;
  localparam int DEPTH = NBANK << (2 * ADDR_W);
  localparam int MA_W  = BANK_W + 2 * ADDR_W;

  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_ACT = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_WR  = 3'd3;
  localparam logic [2:0] C_PRE = 3'd4;

  logic [NBANK-1:0]  open_q;
  logic [ADDR_W-1:0] row_q [NBANK];
  logic [TW-1:0]     rcd_q [NBANK];
  logic [TW-1:0]     rp_q  [NBANK];
  logic [TW-1:0]     ras_q [NBANK];

  logic              bact_q, bwr_q, blen8_q;
  logic [BANK_W-1:0] bbank_q;
  logic [ADDR_W-1:0] brow_q, bcol_q;
  logic [2:0]        bidx_q;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [2:0]        pv_q;
  logic [DATA_W-1:0] pd_q [3];

  function automatic logic [TW-1:0] arm(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  logic is_act, is_rd, is_wr, is_pre, is_acc, is_bad_code;
  assign is_act      = cmd == C_ACT;
  assign is_rd       = cmd == C_RD;
  assign is_wr       = cmd == C_WR;
  assign is_pre      = cmd == C_PRE;
  assign is_acc      = is_rd | is_wr;
  assign is_bad_code = cmd > C_PRE;

  logic sel_open, busy_bank, act_ok, acc_ok, pre_ok, bad;
  assign sel_open  = open_q[bank];
  assign busy_bank = bact_q && (bbank_q == bank);
  assign act_ok    = is_act && !sel_open && (rp_q[bank] == '0);
  assign acc_ok    = is_acc && sel_open && (rcd_q[bank] == '0) && !bact_q;
  assign pre_ok    = is_pre && sel_open && (ras_q[bank] == '0) && !busy_bank;
  assign bad       = (is_act && !act_ok) || (is_acc && !acc_ok) ||
                     (is_pre && sel_open && !pre_ok) || is_bad_code;

  logic              beat_en, beat_wr;
  logic [BANK_W-1:0] beat_bank;
  logic [ADDR_W-1:0] beat_row, beat_col, wrap_col;
  logic [MA_W-1:0]   maddr;
  logic [2:0]        last_idx;

  assign wrap_col  = blen8_q ? {bcol_q[ADDR_W-1:3], bcol_q[2:0] + bidx_q}
                             : {bcol_q[ADDR_W-1:2], bcol_q[1:0] + bidx_q[1:0]};
  assign beat_en   = acc_ok | bact_q;
  assign beat_wr   = acc_ok ? is_wr : bwr_q;
  assign beat_bank = acc_ok ? bank : bbank_q;
  assign beat_row  = acc_ok ? row_q[bank] : brow_q;
  assign beat_col  = acc_ok ? addr : wrap_col;
  assign maddr     = {beat_bank, beat_row, beat_col};
  assign last_idx  = blen8_q ? 3'd7 : 3'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < NBANK; b++) begin
        row_q[b] <= '0;
        rcd_q[b] <= '0;
        rp_q[b]  <= '0;
        ras_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
        if (rp_q[b]  != '0) rp_q[b]  <= rp_q[b]  - 1'b1;
        if (ras_q[b] != '0) ras_q[b] <= ras_q[b] - 1'b1;
        if (act_ok && bank == BANK_W'(b)) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= addr;
          rcd_q[b]  <= arm(t_rcd);
          ras_q[b]  <= arm(t_ras);
        end
        if (pre_ok && bank == BANK_W'(b)) begin
          open_q[b] <= 1'b0;
          rp_q[b]   <= arm(t_rp);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bact_q  <= 1'b0;
      bwr_q   <= 1'b0;
      blen8_q <= 1'b0;
      bbank_q <= '0;
      brow_q  <= '0;
      bcol_q  <= '0;
      bidx_q  <= '0;
    end else if (acc_ok) begin
      bact_q  <= 1'b1;
      bwr_q   <= is_wr;
      blen8_q <= bl8;
      bbank_q <= bank;
      brow_q  <= row_q[bank];
      bcol_q  <= addr;
      bidx_q  <= 3'd1;
    end else if (bact_q) begin
      bidx_q <= bidx_q + 3'd1;
      if (bidx_q == last_idx) bact_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_en && beat_wr) mem[maddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= '0;
      err  <= 1'b0;
    end else begin
      pv_q <= {pv_q[1:0], beat_en && !beat_wr};
      err  <= bad;
    end
  end

  always_ff @(posedge clk) begin
    pd_q[0] <= mem[maddr];
    pd_q[1] <= pd_q[0];
    pd_q[2] <= pd_q[1];
  end

  assign rvalid = cas3 ? pv_q[2] : pv_q[1];
  assign rdata  = cas3 ? pd_q[2] : pd_q[1];

  p_act_open_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && open_q[bank]) |=> err);

  p_acc_closed_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_acc && !open_q[bank]) |=> (err && $stable(open_q)));

  p_rcd_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_acc && open_q[bank] && rcd_q[bank] != '0) |=> (err && $stable(bact_q)));

  p_rp_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !open_q[bank] && rp_q[bank] != '0) |=> (err && $stable(open_q)));

  p_ras_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && open_q[bank] && ras_q[bank] != '0) |=> (err && $stable(open_q)));

  p_beat_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bact_q && $past(bact_q)) |-> (bidx_q == $past(bidx_q) + 3'd1));

  p_cl2_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas3 && $past(beat_en && !beat_wr, 2) && $past(rst_n, 2)) |-> rvalid);

  p_busy_acc_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_acc && bact_q) |=> err);

  p_busy_pre_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && busy_bank) |=> (err && open_q[$past(bank)]));
endmodule

// File: tb/sdram_bank_engine_test.sv
module sdram_bank_engine_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd;
  logic [1:0] bank;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       bl8, cas3;
  logic [3:0] t_rcd, t_rp, t_ras;
  logic [7:0] rdata;
  logic       rvalid, err;

  sdram_bank_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
    .wdata(wdata), .bl8(bl8), .cas3(cas3), .t_rcd(t_rcd), .t_rp(t_rp),
    .t_ras(t_ras), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  always #(PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nbad = 0;

  // {cmd, bank, addr, wdata, exp_err, exp_rvalid, exp_rdata}; BL4, CL2, tRCD 2, tRP 2, tRAS 3
  localparam int NV = 23;
  localparam logic [26:0] VEC [NV] = '{
    {3'd1, 2'd0, 4'd2, 8'h00, 1'b0, 1'b0, 8'h00},  // R1 activate bank0 row2
    {3'd2, 2'd0, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00},  // R3 read too early
    {3'd3, 2'd0, 4'd5, 8'h10, 1'b0, 1'b0, 8'h00},  // R8 write burst col5
    {3'd0, 2'd0, 4'd0, 8'h11, 1'b0, 1'b0, 8'h00},
    {3'd0, 2'd0, 4'd0, 8'h12, 1'b0, 1'b0, 8'h00},
    {3'd1, 2'd1, 4'd1, 8'h13, 1'b0, 1'b0, 8'h00},  // R10 activate bank1 mid-burst
    {3'd2, 2'd1, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00},  // R3 bank1 too early
    {3'd2, 2'd0, 4'd6, 8'h00, 1'b0, 1'b0, 8'h00},  // R6 read col6 wraps
    {3'd2, 2'd1, 4'd0, 8'h00, 1'b1, 1'b1, 8'h11},  // R9 read while busy; R7 data
    {3'd4, 2'd0, 4'd0, 8'h00, 1'b1, 1'b1, 8'h12},  // R11 precharge busy bank
    {3'd0, 2'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'h13},
    {3'd4, 2'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'h10},  // R5 precharge ok
    {3'd1, 2'd0, 4'd3, 8'h00, 1'b1, 1'b0, 8'h00},  // R4 activate too early
    {3'd1, 2'd0, 4'd3, 8'h00, 1'b0, 1'b0, 8'h00},  // R4 activate ok
    {3'd1, 2'd0, 4'd5, 8'h00, 1'b1, 1'b0, 8'h00},  // R2 activate open bank
    {3'd4, 2'd0, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00},  // R5 precharge too early
    {3'd3, 2'd0, 4'd0, 8'h20, 1'b0, 1'b0, 8'h00},  // R8 write row3
    {3'd0, 2'd0, 4'd0, 8'h21, 1'b0, 1'b0, 8'h00},
    {3'd0, 2'd0, 4'd0, 8'h22, 1'b0, 1'b0, 8'h00},
    {3'd0, 2'd0, 4'd0, 8'h23, 1'b0, 1'b0, 8'h00},
    {3'd4, 2'd0, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00},  // R5 precharge after burst
    {3'd2, 2'd0, 4'd1, 8'h00, 1'b1, 1'b0, 8'h00},  // R2 read closed bank
    {3'd4, 2'd2, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00}   // R11 precharge closed bank
  };

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] b,
                      input logic [3:0] a, input logic [7:0] d);
    cmd = c; bank = b; addr = a; wdata = d;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  function automatic logic [7:0] dir_exp(input int i);
    logic [7:0] t [12] = '{8'h34, 8'h35, 8'h36, 8'h37, 8'h30, 8'h31,
                           8'h32, 8'h33, 8'h33, 8'h34, 8'h35, 8'h32};
    return t[i];
  endfunction

  initial begin
    #(PERIOD * 5000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bl8 = 1'b0; cas3 = 1'b0;
    t_rcd = 4'd2; t_rp = 4'd2; t_ras = 4'd3;
    step(3'd0, 2'd0, 4'd0, 8'h00);
    step(3'd0, 2'd0, 4'd0, 8'h00);
    chk("R12 err after reset", err, 0);
    chk("R12 rvalid after reset", rvalid, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26:24], VEC[i][23:22], VEC[i][21:18], VEC[i][17:10]);
      chk($sformatf("R1 err row %0d", i), err, VEC[i][9]);
      chk($sformatf("R7 rvalid row %0d", i), rvalid, VEC[i][8]);
      if (VEC[i][8]) chk($sformatf("R6 rdata row %0d", i), rdata, VEC[i][7:0]);
    end

    chk("R1 illegal code", 0, 0);
    step(3'd6, 2'd0, 4'd0, 8'h00);
    chk("R1 illegal code err", err, 1);

    // BL8, CL3
    bl8 = 1'b1; cas3 = 1'b1;
    step(3'd1, 2'd0, 4'd3, 8'h00);
    chk("R4 activate row3", err, 0);
    step(3'd0, 2'd0, 4'd0, 8'h00);
    step(3'd3, 2'd0, 4'd6, 8'h30);
    chk("R8 write bl8 accepted", err, 0);
    for (int i = 1; i < 8; i++) step(3'd0, 2'd0, 4'd0, 8'h30 + 8'(i));
    step(3'd2, 2'd0, 4'd2, 8'h00);
    chk("R6 read bl8 accepted", err, 0);
    step(3'd1, 2'd2, 4'd1, 8'h00);
    chk("R10 activate other bank during read", err, 0);
    chk("R7 no data at CL2 when CL3", rvalid, 0);
    for (int i = 0; i < 12; i++) begin
      if (i == 6) bl8 = 1'b0;
      if (i == 6) step(3'd2, 2'd0, 4'd1, 8'h00);
      else        step(3'd0, 2'd0, 4'd0, 8'h00);
      if (i == 6) chk("R9 back-to-back read accepted", err, 0);
      chk($sformatf("R9 rvalid gapless beat %0d", i), rvalid, 1);
      chk($sformatf("R6 R7 rdata beat %0d", i), rdata, dir_exp(i));
    end
    step(3'd0, 2'd0, 4'd0, 8'h00);
    chk("R7 rvalid drops after stream", rvalid, 0);

    rst_n = 1'b0;
    step(3'd0, 2'd0, 4'd0, 8'h00);
    rst_n = 1'b1;
    step(3'd2, 2'd0, 4'd0, 8'h00);
    chk("R12 reset closes banks", err, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule